// File: doc/BRIEF.md
# Transfer Counter with FIFO Residue Tracking

This block keeps the byte count and the buffer level of a byte-stream data path. Software stages a transfer length in three byte-wide count registers and then issues a load command, which copies the staged value into a live down-counter. Each byte accepted from the stream side into the internal data FIFO lowers the live count by one. When the count reaches zero a terminal-count flag is raised and no further bytes are accepted.

The count is taken when a byte enters the buffer, not when it leaves. A transfer that stops early therefore leaves bytes that were counted but are still sitting in the FIFO. Software reads back the live count and the FIFO occupancy and adds them to get the residual. Any byte left behind, including a single odd byte, can be pulled out one at a time through the FIFO data register.

A configuration bit selects the counter width. In narrow mode only the low and middle count bytes take part, and a staged value of zero stands for 65536 bytes. In wide mode all 24 bits take part. Every register is one byte wide, and register index i sits at byte address 4*i.

Top module: `xfer_residue_ctr`

## Requirements
- R1: After reset, every register reads 0, in_ready is 0 and out_valid is 0.
- R2: Register index i is decoded only at byte address 4*i. The index map is: 0 count low byte, 1 count middle byte, 2 FIFO data, 3 command, 4 status, 5 FIFO flags, 6 configuration, 7 count high byte. An address with nonzero bits 1:0, or an index above 7, reads 0 and ignores writes.
- R3: A write to a count byte register only stages the value and leaves the live count unchanged. Writing the command register with bit 0 set copies the staged bytes into the live count. Reads of the three count registers return the live count.
- R4: With configuration bit 0 clear (narrow mode), the high byte is ignored when loading, a staged 16-bit value of zero loads 65536, and a read of the count high register returns 0.
- R5: With configuration bit 0 set (wide mode), the load uses all 24 bits. A loaded zero raises terminal count at once, and no byte is accepted.
- R6: in_ready is 1 exactly when the FIFO holds fewer than 16 bytes and the live count is nonzero. Each transfer with in_valid and in_ready both high lowers the live count by one at that clock edge.
- R7: Status bit 4 is the terminal-count flag. It is set at the edge that accepts the byte that brings the live count to zero. Writing any count byte register clears it. A load sets it to whether the loaded value is zero.
- R8: FIFO flags bits 4:0 report the occupancy, from 0 to 16, and bits 7:5 read 0.
- R9: Bytes leave the FIFO in arrival order. One byte leaves per cycle when out_valid is high and either out_ready is high or the FIFO data register is read; both requests in the same cycle remove a single byte. A read of the FIFO data register while the FIFO is empty returns 0.
- R10: At any time, the live count plus the FIFO occupancy plus the bytes already drained equals the loaded count.
- R11: reg_rdata changes only at the clock edge that samples reg_rd high, and then shows the addressed register as it stood before that edge. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| in_valid | input | 1 | Stream byte offered to the FIFO |
| in_data | input | 8 | Stream byte value |
| in_ready | output | 1 | FIFO accepts a byte this cycle |
| out_valid | output | 1 | FIFO holds at least one byte |
| out_data | output | 8 | Oldest byte in the FIFO |
| out_ready | input | 1 | Consumer takes the oldest byte |

## Verification
The bench builds the block with its default parameters: a 16-byte FIFO and a 6-bit address. At that depth a stall with no draining fills the FIFO within a few dozen cycles, so the full, stalled and partly drained residue states all come up in a sweep of counts from 1 to 300 in both widths and under three drain patterns. The narrow zero-load case, 65536 bytes, is run to completion with a drain every cycle, which fits easily within the run length. Expected counts, occupancies and byte order are computed arithmetically, cycle by cycle.

// File: rtl/xcnt_pkg.sv
package xcnt_pkg;

    typedef enum logic [3:0] {
        IDX_CNT_LO  = 4'd0,
        IDX_CNT_MID = 4'd1,
        IDX_FIFO    = 4'd2,
        IDX_CMD     = 4'd3,
        IDX_STAT    = 4'd4,
        IDX_FLAGS   = 4'd5,
        IDX_CFG     = 4'd6,
        IDX_CNT_HI  = 4'd7
    } reg_idx_e;

    localparam int BYTE_W       = 8;
    localparam int CNT_BYTES    = 3;
    localparam int CNT_W        = CNT_BYTES * BYTE_W;
    localparam int NARROW_W     = 16;
    localparam int STAT_TC_BIT  = 4;
    localparam int CMD_LOAD_BIT = 0;
    localparam int CFG_WIDE_BIT = 0;

endpackage

// File: rtl/xcnt_fifo.sv
module xcnt_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [OW-1:0] occ,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [OW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         push_ok, pop_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == OW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[st_q.rp];
    assign occ     = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wp = step(st_q.wp);
        if (pop_ok)  st_d.rp = step(st_q.rp);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= din;
    end

endmodule

// File: rtl/xcnt_counter.sv
module xcnt_counter #(
    parameter int LW = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          dec,
    input  logic          clr_tc,
    output logic [LW-1:0] live,
    output logic          tc
);

    typedef struct packed {
        logic [LW-1:0] live;
        logic          tc;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dec && (st_q.live != '0)) begin
            st_d.live = st_q.live - 1'b1;
            if (st_q.live == LW'(1)) st_d.tc = 1'b1;
        end
        if (clr_tc) st_d.tc = 1'b0;
        if (load) begin
            st_d.live = load_val;
            st_d.tc   = (load_val == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live = st_q.live;
    assign tc   = st_q.tc;

endmodule

// File: rtl/xfer_residue_ctr.sv
module xfer_residue_ctr
    import xcnt_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int OW    = $clog2(FIFO_DEPTH + 1);
    localparam int LW    = CNT_W + 1;

    typedef struct packed {
        logic [7:0] stage_lo;
        logic [7:0] stage_mid;
        logic [7:0] stage_hi;
        logic       wide;
        logic [7:0] rdata;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             wr_lo, wr_mid, wr_hi, wr_cmd, wr_cfg, rd_fifo;
    logic             cnt_load, cnt_clr_tc, push, pop;
    logic [LW-1:0]    load_val, live_cnt;
    logic [NARROW_W-1:0] narrow_val;
    logic             tc_flag, wide_mode;
    logic [OW-1:0]    fifo_occ;
    logic             fifo_full, fifo_empty;
    logic [7:0]       fifo_head, rd_mux;

    // register decode
    assign idx     = reg_addr[ADDR_W-1:2];
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign wr_lo   = reg_wr && aligned && (idx == IDX_W'(IDX_CNT_LO));
    assign wr_mid  = reg_wr && aligned && (idx == IDX_W'(IDX_CNT_MID));
    assign wr_hi   = reg_wr && aligned && (idx == IDX_W'(IDX_CNT_HI));
    assign wr_cmd  = reg_wr && aligned && (idx == IDX_W'(IDX_CMD));
    assign wr_cfg  = reg_wr && aligned && (idx == IDX_W'(IDX_CFG));
    assign rd_fifo = reg_rd && aligned && (idx == IDX_W'(IDX_FIFO));

    // load value: narrow zero stands for a full 64 KiB transfer
    assign narrow_val = {st_q.stage_mid, st_q.stage_lo};
    assign load_val   = st_q.wide ? {1'b0, st_q.stage_hi, st_q.stage_mid, st_q.stage_lo}
                      : (narrow_val == '0) ? (LW'(1) << NARROW_W)
                      : LW'(narrow_val);
    assign cnt_load   = wr_cmd && reg_wdata[CMD_LOAD_BIT];
    assign cnt_clr_tc = wr_lo || wr_mid || wr_hi;

    // stream side
    assign in_ready  = !fifo_full && (live_cnt != '0);
    assign push      = in_valid && in_ready;
    assign pop       = !fifo_empty && (out_ready || rd_fifo);
    assign out_valid = !fifo_empty;
    assign out_data  = fifo_head;
    assign wide_mode = st_q.wide;

    xcnt_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (in_data),
        .head  (fifo_head),
        .occ   (fifo_occ),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    xcnt_counter #(.LW(LW)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (load_val),
        .dec      (push),
        .clr_tc   (cnt_clr_tc),
        .live     (live_cnt),
        .tc       (tc_flag)
    );

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(IDX_CNT_LO):  rd_mux = live_cnt[7:0];
                IDX_W'(IDX_CNT_MID): rd_mux = live_cnt[15:8];
                IDX_W'(IDX_CNT_HI):  rd_mux = st_q.wide ? live_cnt[23:16] : 8'h00;
                IDX_W'(IDX_FIFO):    rd_mux = fifo_empty ? 8'h00 : fifo_head;
                IDX_W'(IDX_STAT):    rd_mux[STAT_TC_BIT] = tc_flag;
                IDX_W'(IDX_FLAGS):   rd_mux = 8'(fifo_occ);
                IDX_W'(IDX_CFG):     rd_mux[CFG_WIDE_BIT] = st_q.wide;
                default:             rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_lo)  st_d.stage_lo  = reg_wdata;
        if (wr_mid) st_d.stage_mid = reg_wdata;
        if (wr_hi)  st_d.stage_hi  = reg_wdata;
        if (wr_cfg) st_d.wide      = reg_wdata[CFG_WIDE_BIT];
        if (reg_rd) st_d.rdata     = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

endmodule

// File: rtl/xcnt_checker.sv
module xcnt_checker #(
    parameter int FIFO_DEPTH = 16,
    parameter int ADDR_W     = 6,
    parameter int OW         = 5,
    parameter int LW         = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [7:0]        reg_rdata,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [OW-1:0]     occ,
    input logic [LW-1:0]     live,
    input logic              tc,
    input logic              wide
);

    // R8: occupancy never exceeds the FIFO depth
    a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(FIFO_DEPTH));

    // R6: a full FIFO blocks the stream side
    a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OW'(FIFO_DEPTH)) |-> !in_ready);

    // R6: an exhausted count blocks the stream side
    a_r6_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (live == '0) |-> !in_ready);

    // R6: each accepted byte lowers the count by exactly one
    a_r6_dec_one: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !reg_wr) |=> (live == $past(live) - LW'(1)));

    // R7: the last accepted byte raises terminal count
    a_r7_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !reg_wr && live == LW'(1)) |=> tc);

    // R4: the high count byte reads zero in narrow mode
    a_r4_hi_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(28) && !wide) |=> (reg_rdata == 8'h00));

    // R9: out_valid tracks a nonempty FIFO
    a_r9_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (occ != '0));

    // R11: read data holds without a read strobe
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind xfer_residue_ctr xcnt_checker #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .ADDR_W     (ADDR_W),
    .OW         (OW),
    .LW         (LW)
) u_xcnt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .occ       (fifo_occ),
    .live      (live_cnt),
    .tc        (tc_flag),
    .wide      (wide_mode)
);

// File: tb/test_xfer_residue_ctr.sv
`timescale 1ns/1ps
module test_xfer_residue_ctr;

    localparam int A_LO = 0, A_MID = 4, A_FIFO = 8, A_CMD = 12;
    localparam int A_STAT = 16, A_FLAGS = 20, A_CFG = 24, A_HI = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;

    int nvec = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    xfer_residue_ctr i_xfer_residue_ctr (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    task automatic chk(input int act, input int exp, input string what);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 6'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 6'(a); reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = int'(reg_rdata);
    endtask

    // load n, stream bytes for a number of cycles under a drain pattern,
    // then check count, residue and FIFO contents
    task automatic run(input int n, input bit wmode, input int pat, input int cycles);
        int  mlive, mocc, acc, popped, loaded, lo, mid, hi, fl, st, v, left;
        bit  mtc, exp_rdy, pop;
        wr(A_CFG, int'(wmode));
        wr(A_LO, n & 255);
        wr(A_MID, (n >> 8) & 255);
        wr(A_HI, (n >> 16) & 255);
        wr(A_CMD, 1);
        loaded = wmode ? (n & 24'hFFFFFF)
               : (((n & 16'hFFFF) == 0) ? 65536 : (n & 16'hFFFF));
        mlive = loaded; mtc = (loaded == 0); mocc = 0; acc = 0; popped = 0;
        rd(A_STAT, st);
        chk(st, mtc ? 16 : 0, "R7 R5 terminal count after load");
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_data   = 8'(acc);
            out_ready = (pat == 1) || (pat == 2 && (c % 3) == 0);
            exp_rdy   = (mocc < 16) && (mlive != 0);
            chk(int'(in_ready), int'(exp_rdy), "R6 in_ready");
            chk(int'(out_valid), int'(mocc > 0), "R9 out_valid");
            if (mocc > 0) chk(int'(out_data), popped & 255, "R9 out_data order");
            pop = out_ready && (mocc > 0);
            if (exp_rdy) begin
                mlive--; acc++; mocc++;
                if (mlive == 0) mtc = 1'b1;
            end
            if (pop) begin popped++; mocc--; end
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        rd(A_LO, lo);  chk(lo, mlive & 255, "R6 live count low byte");
        rd(A_MID, mid); chk(mid, (mlive >> 8) & 255, "R6 live count middle byte");
        rd(A_HI, hi);
        chk(hi, wmode ? ((mlive >> 16) & 255) : 0, "R4 R5 high byte readback");
        rd(A_FLAGS, fl); chk(fl, mocc, "R8 FIFO flags occupancy");
        rd(A_STAT, st);  chk(st, mtc ? 16 : 0, "R7 terminal count");
        chk(lo + (mid << 8) + (hi << 16) + fl + popped, loaded, "R10 residue sum");
        left = mocc;
        for (int k = 0; k < left; k++) begin
            rd(A_FIFO, v);
            chk(v, (popped + k) & 255, "R9 FIFO register read order");
        end
        rd(A_FIFO, v);   chk(v, 0, "R9 empty FIFO read");
        rd(A_FLAGS, fl); chk(fl, 0, "R8 flags after drain");
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog (all requirements): got running expected finished");
        summary();
        $finish;
    end

    initial begin
        int v;
        int counts [8] = '{1, 2, 3, 15, 16, 17, 40, 300};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(int'(in_ready), 0, "R1 in_ready after reset");
        chk(int'(out_valid), 0, "R1 out_valid after reset");
        chk(int'(reg_rdata), 0, "R1 rdata after reset");
        for (int i = 0; i < 8; i++) begin
            rd(i * 4, v);
            chk(v, 0, "R1 register reads zero after reset");
        end

        // R2: address decode
        wr(A_CFG, 1);
        rd(A_CFG + 2, v); chk(v, 0, "R2 misaligned read");
        rd(A_CFG, v);     chk(v, 1, "R2 config readback");
        wr(A_CFG + 1, 0);
        rd(A_CFG, v);     chk(v, 1, "R2 misaligned write ignored");
        rd(9 * 4, v);     chk(v, 0, "R2 unmapped index reads zero");
        wr(12 * 4, 0);
        rd(A_CFG, v);     chk(v, 1, "R2 unmapped write ignored");
        wr(A_CFG, 0);

        // R3: staging versus load
        wr(A_LO, 5);
        rd(A_LO, v); chk(v, 0, "R3 staged write leaves live count");
        wr(A_CMD, 0);
        rd(A_LO, v); chk(v, 0, "R3 command without load bit");
        wr(A_CMD, 1);
        rd(A_LO, v); chk(v, 5, "R3 load copies staged value");
        chk(int'(in_ready), 1, "R6 ready after nonzero load");
        wr(A_LO, 0); wr(A_CMD, 1);

        // sweep
        for (int w = 0; w < 2; w++)
            for (int p = 0; p < 3; p++)
                foreach (counts[j]) begin
                    int cyc;
                    cyc = counts[j] * 3 + 24;
                    if (cyc > 400) cyc = 400;
                    run(counts[j], w[0], p, cyc);
                end

        // R4: high byte ignored in narrow mode; R5 wide uses it
        run(32'h012345, 1'b0, 1, 30);
        run(32'h012345, 1'b1, 1, 30);

        // R7: count write clears terminal count, live unchanged
        run(3, 1'b0, 1, 30);
        wr(A_LO, 7);
        rd(A_STAT, v); chk(v, 0, "R7 count write clears TC");
        rd(A_LO, v);   chk(v, 0, "R3 count write leaves live count");

        // R5: wide zero load
        run(0, 1'b1, 1, 10);
        wr(A_HI, 0);
        rd(A_STAT, v); chk(v, 0, "R7 high byte write clears TC");

        // R4: narrow zero means 65536 bytes
        run(0, 1'b0, 1, 65536 + 10);

        // R11: read data holds
        rd(A_CFG, v);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(int'(reg_rdata), v, "R11 read data holds");
        end

        summary();
        $finish;
    end

endmodule